// File: doc/BRIEF.md
# Weighted Slot Scheduler for a Sixteen-Channel Timer Engine

This block decides which timer channel a shared service engine works on during each time slot. Every channel carries a two-bit priority code and a two-bit service request. The code either switches the channel off or places it in one of three levels: low, middle or high. At every slot boundary the block picks one channel that is both enabled and requesting. A fixed seven-slot rotation gives the high, middle and low levels four, two and one slots respectively.

A slot whose own level has nothing waiting is not wasted. It passes to the first level that does have work, checked in the order high, middle, low. Inside a level, channels take turns in round-robin order. A grant does not consume the request. The request stays pending until the engine reports completion for that channel, and the block then clears the field to zero. The host sees that zero as the sign that the work is finished.

The host reaches the codes and the requests through a small write port with four word addresses.

Top module: `slot_sched`

## Requirements
- R1: After reset every priority and request field is 00, so every channel is disabled. The rotation stands at its first slot, and no grant is issued even when requests are then written.
- R2: Word addresses are as follows: 0 holds the priority fields of channels 15..8, 1 holds those of channels 7..0, 2 holds the request fields of channels 15..8, and 3 holds those of channels 7..0. Channel n uses bits 2*(n mod 8)+1 : 2*(n mod 8) of its word. The priority codes are 00 disabled, 01 low, 10 middle and 11 high, and writing a priority word replaces all eight fields.
- R3: A channel is pending only when its request is non-zero and its priority is not 00. A channel that is not pending is never granted.
- R4: A request write stores each non-zero field. A field written as 00 leaves that channel's request unchanged.
- R5: The slot levels repeat as high, middle, high, low, high, middle, high. The rotation advances by one position on every slotStart pulse, including pulses that end in an idle slot.
- R6: If the slot's own level has no pending channel, the slot goes to the first pending level in the order high, middle, low. If nothing is pending, no grant is issued.
- R7: Within a level, the grant goes to the next pending channel after the one last granted at that level, wrapping from 15 to 0. At reset the search starts at channel 0.
- R8: grantValid is a one-cycle pulse in the cycle after the clock edge that samples slotStart. grantChan is valid in that same cycle, and there is no grant without slotStart.
- R9: A doneValid pulse clears the request of channel doneChan at the clock edge. A non-zero host write to the same field in the same cycle takes precedence over the clear.
- R10: A grant leaves the request untouched, so a granted channel stays pending until completion is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register word address |
| wrData | input | 16 | Register write data |
| slotStart | input | 1 | Start of a time slot |
| doneValid | input | 1 | Engine reports that service is complete |
| doneChan | input | 4 | Channel whose service is complete |
| grantValid | output | 1 | A channel is granted for this slot |
| grantChan | output | 4 | Granted channel number |

## Verification
The grant is registered once. Its result appears in the cycle after the rising edge that samples slotStart, so the bench raises slotStart at a falling edge and reads grantValid and grantChan at the next falling edge. Register writes and completion reports also take effect at the first rising edge. They are therefore judged through the grant of a later slot and never in the cycle they are applied. Because every slot advances the rotation, the bench counts slot pulses to know which level each slot belongs to, idle slots included.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  typedef enum logic [1:0] {
    PRIO_OFF  = 2'b00,
    PRIO_LOW  = 2'b01,
    PRIO_MID  = 2'b10,
    PRIO_HIGH = 2'b11
  } prio_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic  grantStb;
    prio_e lvl;
  } schedStrobe_t;

endpackage

// File: rtl/slot_sched_rr_pick.sv
module slot_sched_rr_pick #(
  parameter int NUM_CHAN = 16,
  localparam int CHAN_W = $clog2(NUM_CHAN)
) (
  input  logic [NUM_CHAN-1:0] candMask,
  input  logic [CHAN_W-1:0]   lastIdx,
  output logic                found,
  output logic [CHAN_W-1:0]   pickIdx
);

  // search starts just after the last served channel and wraps around
  always_comb begin
    found   = 1'b0;
    pickIdx = lastIdx;
    for (int k = 1; k <= NUM_CHAN; k++) begin
      if (!found && candMask[(int'(lastIdx) + k) % NUM_CHAN]) begin
        found   = 1'b1;
        pickIdx = CHAN_W'((int'(lastIdx) + k) % NUM_CHAN);
      end
    end
  end

endmodule

// File: rtl/slot_sched_ctrl.sv
module slot_sched_ctrl
  import slot_sched_pkg::*;
#(
  parameter int CYCLE_LEN = 7,
  localparam int POS_W = $clog2(CYCLE_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotStart,
  input  logic [2:0]       lvlPend,   // bit0 low, bit1 middle, bit2 high
  output schedStrobe_t     strobe,
  output logic [POS_W-1:0] slotPos
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CYCLE_LEN - 1);
  localparam logic [POS_W-1:0] LOW_POS  = POS_W'(3);

  prio_e target;
  prio_e chosen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotPos <= '0;
    end else if (slotStart) begin
      slotPos <= (slotPos == LAST_POS) ? '0 : slotPos + 1'b1;
    end
  end

  // even positions are high, position three is low, the rest are middle
  always_comb begin
    if (!slotPos[0])            target = PRIO_HIGH;
    else if (slotPos == LOW_POS) target = PRIO_LOW;
    else                        target = PRIO_MID;
  end

  always_comb begin
    if (lvlPend[2'(target) - 2'd1]) chosen = target;
    else if (lvlPend[2])            chosen = PRIO_HIGH;
    else if (lvlPend[1])            chosen = PRIO_MID;
    else                            chosen = PRIO_LOW;
  end

  always_comb begin
    strobe.grantStb = slotStart && (|lvlPend);
    strobe.lvl      = chosen;
  end

endmodule

// File: rtl/slot_sched_datapath.sv
module slot_sched_datapath
  import slot_sched_pkg::*;
#(
  parameter int NUM_CHAN = 16,
  parameter int REG_W    = 16,
  localparam int CHAN_W        = $clog2(NUM_CHAN),
  localparam int CH_PER_REG    = REG_W / 2,
  localparam int NUM_PRIO_REGS = NUM_CHAN / CH_PER_REG,
  localparam int ADDR_W        = $clog2(2 * NUM_PRIO_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [REG_W-1:0]      wrData,
  input  logic                  doneValid,
  input  logic [CHAN_W-1:0]     doneChan,
  input  schedStrobe_t          strobe,
  output logic [2:0]            lvlPend,
  output logic                  grantValid,
  output logic [CHAN_W-1:0]     grantChan,
  output logic [2*NUM_CHAN-1:0] prioFlat,
  output logic [2*NUM_CHAN-1:0] reqFlat
);

  logic [2*NUM_CHAN-1:0]    nextPrio;
  logic [2*NUM_CHAN-1:0]    nextReq;
  logic [2:0][NUM_CHAN-1:0] lvlMask;
  logic [2:0][CHAN_W-1:0]   lastServed;
  logic [2:0][CHAN_W-1:0]   lvlPick;
  logic [2:0]               lvlFound;
  logic [1:0]               selLvl;

  // next state of the host-visible fields
  always_comb begin
    nextPrio = prioFlat;
    nextReq  = reqFlat;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (wrEn && wrAddr == ADDR_W'(NUM_PRIO_REGS - 1 - c / CH_PER_REG))
        nextPrio[2*c +: 2] = wrData[2*(c % CH_PER_REG) +: 2];
      if (doneValid && doneChan == CHAN_W'(c))
        nextReq[2*c +: 2] = 2'b00;
      if (wrEn && wrAddr == ADDR_W'(2*NUM_PRIO_REGS - 1 - c / CH_PER_REG) &&
          wrData[2*(c % CH_PER_REG) +: 2] != 2'b00)
        nextReq[2*c +: 2] = wrData[2*(c % CH_PER_REG) +: 2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioFlat <= '0;
      reqFlat  <= '0;
    end else begin
      prioFlat <= nextPrio;
      reqFlat  <= nextReq;
    end
  end

  // per-channel pending masks, split by level
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic chanPend;
    assign chanPend = (reqFlat[2*c +: 2] != 2'b00) &&
                      (prio_e'(prioFlat[2*c +: 2]) != PRIO_OFF);
    for (genvar l = 0; l < 3; l++) begin : g_lvl
      assign lvlMask[l][c] = chanPend && (prioFlat[2*c +: 2] == 2'(l + 1));
    end
  end

  // one round-robin picker per level
  for (genvar l = 0; l < 3; l++) begin : g_pick
    slot_sched_rr_pick #(.NUM_CHAN(NUM_CHAN)) u_pick (
      .candMask (lvlMask[l]),
      .lastIdx  (lastServed[l]),
      .found    (lvlFound[l]),
      .pickIdx  (lvlPick[l])
    );
    assign lvlPend[l] = |lvlMask[l];
  end

  assign selLvl = 2'(strobe.lvl) - 2'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantChan  <= '0;
      lastServed <= {3{CHAN_W'(NUM_CHAN - 1)}};
    end else begin
      grantValid <= strobe.grantStb && lvlFound[selLvl];
      if (strobe.grantStb && lvlFound[selLvl]) begin
        grantChan          <= lvlPick[selLvl];
        lastServed[selLvl] <= lvlPick[selLvl];
      end
    end
  end

endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int NUM_CHAN  = 16,
  parameter int REG_W     = 16,
  parameter int CYCLE_LEN = 7,
  localparam int CHAN_W        = $clog2(NUM_CHAN),
  localparam int CH_PER_REG    = REG_W / 2,
  localparam int NUM_PRIO_REGS = NUM_CHAN / CH_PER_REG,
  localparam int ADDR_W        = $clog2(2 * NUM_PRIO_REGS),
  localparam int POS_W         = $clog2(CYCLE_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              slotStart,
  input  logic              doneValid,
  input  logic [CHAN_W-1:0] doneChan,
  output logic              grantValid,
  output logic [CHAN_W-1:0] grantChan
);

  schedStrobe_t          strobe;
  logic [2:0]            lvlPend;
  logic [POS_W-1:0]      slotPos;
  logic [2*NUM_CHAN-1:0] prioFlat;
  logic [2*NUM_CHAN-1:0] reqFlat;

  slot_sched_ctrl #(.CYCLE_LEN(CYCLE_LEN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .slotStart (slotStart),
    .lvlPend   (lvlPend),
    .strobe    (strobe),
    .slotPos   (slotPos)
  );

  slot_sched_datapath #(.NUM_CHAN(NUM_CHAN), .REG_W(REG_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .doneValid  (doneValid),
    .doneChan   (doneChan),
    .strobe     (strobe),
    .lvlPend    (lvlPend),
    .grantValid (grantValid),
    .grantChan  (grantChan),
    .prioFlat   (prioFlat),
    .reqFlat    (reqFlat)
  );

endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
  parameter int NUM_CHAN  = 16,
  parameter int REG_W     = 16,
  parameter int CYCLE_LEN = 7,
  localparam int CHAN_W        = $clog2(NUM_CHAN),
  localparam int CH_PER_REG    = REG_W / 2,
  localparam int NUM_PRIO_REGS = NUM_CHAN / CH_PER_REG,
  localparam int ADDR_W        = $clog2(2 * NUM_PRIO_REGS),
  localparam int POS_W         = $clog2(CYCLE_LEN)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic [REG_W-1:0]      wrData,
  input logic                  slotStart,
  input logic                  doneValid,
  input logic [CHAN_W-1:0]     doneChan,
  input logic                  grantValid,
  input logic [CHAN_W-1:0]     grantChan,
  input logic [POS_W-1:0]      slotPos,
  input logic [2*NUM_CHAN-1:0] prioFlat,
  input logic [2*NUM_CHAN-1:0] reqFlat
);

  logic [2*NUM_CHAN-1:0] prevPrio;
  logic [2*NUM_CHAN-1:0] prevReq;
  logic                  prevDone;
  logic                  prevWr;
  logic [CHAN_W-1:0]     prevDoneChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPrio     <= '0;
      prevReq      <= '0;
      prevDone     <= 1'b0;
      prevWr       <= 1'b0;
      prevDoneChan <= '0;
    end else begin
      prevPrio     <= prioFlat;
      prevReq      <= reqFlat;
      prevDone     <= doneValid;
      prevWr       <= wrEn;
      prevDoneChan <= doneChan;
    end
  end

  p_pending_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (prevPrio[2*grantChan +: 2] != 2'b00) &&
                   (prevReq[2*grantChan +: 2] != 2'b00));

  p_zero_write_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(2*NUM_PRIO_REGS - 1) && wrData == '0 && !doneValid)
      |=> $stable(reqFlat[REG_W-1:0]));

  p_pos_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    slotPos < POS_W'(CYCLE_LEN));

  p_pos_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |=> slotPos == (($past(slotPos) == POS_W'(CYCLE_LEN - 1)) ? '0
                                                                        : $past(slotPos) + 1'b1));

  p_pos_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !slotStart |=> $stable(slotPos));

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rstN)
    !slotStart |=> !grantValid);

  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (prevDone && !prevWr) |-> reqFlat[2*prevDoneChan +: 2] == 2'b00);

endmodule

bind slot_sched slot_sched_chk #(
  .NUM_CHAN (NUM_CHAN),
  .REG_W    (REG_W),
  .CYCLE_LEN(CYCLE_LEN)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .slotStart  (slotStart),
  .doneValid  (doneValid),
  .doneChan   (doneChan),
  .grantValid (grantValid),
  .grantChan  (grantChan),
  .slotPos    (slotPos),
  .prioFlat   (prioFlat),
  .reqFlat    (reqFlat)
);

// File: tb/slot_sched_bench.sv
module slot_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TBL_N      = 34;

  // entry: {op, addr, data, expValid, chan}; op 0 write, 1 slot, 2 done
  localparam logic [24:0] TBL [TBL_N] = '{
    {2'd0, 2'd1, 16'h042F, 1'b0, 4'd0},   // ch0,1 high, ch2 mid, ch5 low (R2)
    {2'd0, 2'd3, 16'h0415, 1'b0, 4'd0},   // requests ch0,1,2,5
    {2'd0, 2'd2, 16'h0008, 1'b0, 4'd0},   // ch9 request while disabled (R3)
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd0},   // pos0 H
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd2},   // pos1 M
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd1},   // pos2 H
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd5},   // pos3 L
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd0},   // pos4 H
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd2},   // pos5 M
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd1},   // pos6 H
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd0},   // pos0 H
    {2'd2, 2'd0, 16'h0000, 1'b0, 4'd0},
    {2'd2, 2'd0, 16'h0000, 1'b0, 4'd1},
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd2},   // pos1 M
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd2},   // pos2 H -> M (R6)
    {2'd2, 2'd0, 16'h0000, 1'b0, 4'd2},
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd5},   // pos3 L
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd5},   // pos4 H -> L (R6)
    {2'd2, 2'd0, 16'h0000, 1'b0, 4'd5},
    {2'd1, 2'd0, 16'h0000, 1'b0, 4'd0},   // pos5 idle
    {2'd1, 2'd0, 16'h0000, 1'b0, 4'd0},   // pos6 idle
    {2'd0, 2'd2, 16'h0000, 1'b0, 4'd0},   // zero write ignored (R4)
    {2'd0, 2'd0, 16'h000C, 1'b0, 4'd0},   // ch9 high
    {2'd0, 2'd3, 16'h0010, 1'b0, 4'd0},   // ch2 request again
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd9},   // pos0 H
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd2},   // pos1 M
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd9},   // pos2 H
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd9},   // pos3 L -> H (R6)
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd9},   // pos4 H
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd2},   // pos5 M
    {2'd2, 2'd0, 16'h0000, 1'b0, 4'd9},
    {2'd1, 2'd0, 16'h0000, 1'b1, 4'd2},   // pos6 H -> M
    {2'd2, 2'd0, 16'h0000, 1'b0, 4'd2},
    {2'd1, 2'd0, 16'h0000, 1'b0, 4'd0}    // pos0 idle
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        slotStart = 1'b0;
  logic        doneValid = 1'b0;
  logic [3:0]  doneChan = '0;
  logic        grantValid;
  logic [3:0]  grantChan;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_sched u_slot_sched (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .slotStart  (slotStart),
    .doneValid  (doneValid),
    .doneChan   (doneChan),
    .grantValid (grantValid),
    .grantChan  (grantChan)
  );

  task automatic check(input string tag, input logic expV, input logic [3:0] expCh);
    checks++;
    if (grantValid !== expV || (expV && grantChan !== expCh)) begin
      errors++;
      $display("FAIL %s: got valid=%0b chan=%0d, expected valid=%0b chan=%0d",
               tag, grantValid, grantChan, expV, expCh);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doDone(input logic [3:0] ch);
    @(negedge clk);
    doneValid = 1'b1; doneChan = ch;
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic doSlot(input string tag, input logic expV, input logic [3:0] expCh);
    @(negedge clk);
    slotStart = 1'b1;
    @(negedge clk);
    slotStart = 1'b0;
    check(tag, expV, expCh);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    applyReset();
    // R1: idle after reset, and requests alone cannot produce a grant
    @(negedge clk);
    check("R1 reset grant low", 1'b0, 4'd0);
    doWrite(2'd2, 16'h5555);
    doWrite(2'd3, 16'h5555);
    doSlot("R1 R3 all channels disabled", 1'b0, 4'd0);
    applyReset();

    // R2 R3 R4 R5 R6 R7 R9: table walk from the first rotation slot
    for (int i = 0; i < TBL_N; i++) begin
      case (TBL[i][24:23])
        2'd0: doWrite(TBL[i][22:21], TBL[i][20:5]);
        2'd2: doDone(TBL[i][3:0]);
        default: doSlot($sformatf("R5 R6 R7 table step %0d", i), TBL[i][4], TBL[i][3:0]);
      endcase
    end

    // rotation is now at pos1; ch0 high request only
    doWrite(2'd3, 16'h0001);
    doSlot("R6 pos1 middle falls to high", 1'b1, 4'd0);
    @(negedge clk);
    check("R8 grant lasts one cycle", 1'b0, 4'd0);
    doSlot("R10 grant keeps request", 1'b1, 4'd0);          // pos2

    // R9: done and non-zero write to ch0 in one cycle, write wins
    @(negedge clk);
    doneValid = 1'b1; doneChan = 4'd0;
    wrEn = 1'b1; wrAddr = 2'd3; wrData = 16'h0002;
    @(negedge clk);
    doneValid = 1'b0; wrEn = 1'b0;
    doSlot("R9 write beats done", 1'b1, 4'd0);              // pos3 L -> H
    doDone(4'd0);
    doSlot("R9 done clears request", 1'b0, 4'd0);           // pos4

    // R7: wrap within the high level (ch9, ch14, ch15)
    doWrite(2'd0, 16'hF00C);
    doWrite(2'd2, 16'h5004);
    doSlot("R7 rr from last high ch0", 1'b1, 4'd9);         // pos5
    doSlot("R7 rr next", 1'b1, 4'd14);                      // pos6
    doSlot("R7 rr top channel", 1'b1, 4'd15);               // pos0
    doSlot("R7 rr wraps to low index", 1'b1, 4'd9);         // pos1

    // R2 R3: priority word cleared disables the pending channels
    doWrite(2'd0, 16'h0000);
    doSlot("R2 R3 disabled by priority write", 1'b0, 4'd0); // pos2

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule